// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the part of an I2C master that finishes a byte: it either clocks out the acknowledge bit that answers a received byte, or it ends the transfer with a Stop condition. Software requests a sequence with a one-cycle pulse. `ack_go` starts an acknowledge and latches `ack_val` as the bit to send (0 means ACK, 1 means NACK). `stop_go` starts a Stop. Each request sets an enable bit, shown as `ack_busy` or `stop_busy`. The block clears that bit itself when the sequence is done, and it raises `irq` at the same time.

Every timed phase uses a down-counter. The counter is loaded from `reload` and gives a phase of N+1 system clocks, where N is the reload value and a value of 0 counts as 1. The lines are open-drain, so the block only drives enables (`scl_drive_low`, `sda_drive_low`). It reads both lines back through a two-flop synchronizer. A phase that waits for a line to rise does not start counting until the synchronized sample shows that level. A slave that stretches the clock therefore lengthens the sequence and does not shorten the high time.

The block also holds the transmit data buffer. A buffer write that arrives while either enable is set is rejected and sets `wcol`. `stop_det` reports that a Stop was seen on the bus. It stays set until the next Start, which is signalled on `start_seen`.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: One cycle after the cycle in which `ack_go` is sampled, `scl_drive_low` is asserted for exactly N+1 clocks. Throughout this low phase `sda_drive_low` equals the inverse of the latched `ack_val`: 0 drives SDA low (ACK) and 1 leaves SDA released (NACK).
- R2: After the acknowledge low phase the block releases SCL. It starts counting the N+1-clock high phase only once the synchronized SCL reads high. Without stretching, the SCL line is high for N+4 clocks. When a slave holds SCL low, the line is still high for N+4 clocks after it rises. SDA does not change while SCL is released.
- R3: At the end of the acknowledge, `ack_busy` clears and `irq` sets in the same cycle. From then on SCL is held low and SDA is released.
- R4: A Stop request waits, with SDA released, while the synchronized SCL reads high. It starts only once SCL is sampled low. It then drives SDA low while keeping SCL low.
- R5: From the point SDA goes low, SCL stays low for N+4 clocks and is then released. From the point the SCL line is high, SDA stays low for N+4 clocks and is then released.
- R6: `stop_det` sets only when SDA and SCL are both sampled high after SDA has been released. If another device holds SDA low, `stop_det` stays 0 and the Stop does not finish.
- R7: N+1 clocks after `stop_det` sets, `stop_busy` clears, `irq` sets, and both drive enables are 0.
- R8: A buffer write while `ack_busy` or `stop_busy` is set leaves `buf_data` unchanged and sets `wcol`. A write while both are clear stores `buf_wdata` and does not set `wcol`.
- R9: A pulse on `irq_clr` clears `irq`, a pulse on `wcol_clr` clears `wcol`, and a pulse on `start_seen` clears `stop_det`. A set event in the same cycle wins over the clear.
- R10: When `ack_go` and `stop_go` arrive in the same cycle, the acknowledge runs first. The Stop starts after the acknowledge has finished.
- R11: A reload value of 0 behaves as 1, so the acknowledge low phase lasts 2 clocks.
- R12: After reset both drive enables are 0. `ack_busy`, `stop_busy`, `irq`, `stop_det` and `wcol` are 0, and `buf_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | RW | Baud counter reload value N |
| ack_go | input | 1 | Pulse: start an acknowledge sequence |
| ack_val | input | 1 | Acknowledge bit latched with `ack_go` (0 ACK, 1 NACK) |
| stop_go | input | 1 | Pulse: start a Stop sequence |
| buf_wr | input | 1 | Pulse: write `buf_wdata` to the data buffer |
| buf_wdata | input | DW | Buffer write data |
| irq_clr | input | 1 | Pulse: clear `irq` |
| wcol_clr | input | 1 | Pulse: clear `wcol` |
| start_seen | input | 1 | Pulse: a Start has begun, clear `stop_det` |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| ack_busy | output | 1 | Acknowledge enable bit, self-clearing |
| stop_busy | output | 1 | Stop enable bit, self-clearing |
| irq | output | 1 | Sequence-complete interrupt flag |
| stop_det | output | 1 | Stop condition detected on the bus |
| wcol | output | 1 | Buffer write collision flag |
| buf_data | output | DW | Data buffer contents |

## Verification
The assertions are checked on every cycle:
- rejected buffer writes leave the buffer unchanged, and every rise of `wcol` follows a write made while busy;
- the self-clearing of either enable always comes with `irq`;
- `stop_det` only rises inside a Stop sequence;
- SDA is never driven while the block is idle;
- SDA stays steady while the acknowledge holds SCL released.

The phase lengths can only be shown by the bench's scenarios: the N+1 and N+4 clock counts, the stretched high phase, and the zero-reload case. The same holds for the ordering rules, namely a Stop held back while SCL is high, ack-before-stop priority, and a Stop stalled by a held-low SDA.

// File: rtl/i2cas_pkg.sv
package i2cas_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_LOW,
        ST_ACK_REL,
        ST_ACK_HIGH,
        ST_STP_SDA,
        ST_STP_LOW,
        ST_STP_REL,
        ST_STP_HIGH,
        ST_STP_FREE,
        ST_STP_TAIL
    } seq_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } bus_drive_t;

    // Line pull-down pattern for each phase of the two sequences.
    function automatic bus_drive_t phase_drive(seq_state_e st, logic hold_scl, logic ack_bit);
        bus_drive_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (st)
            ST_IDLE:     d.scl_low = hold_scl;
            ST_ACK_LOW:  begin d.scl_low = 1'b1; d.sda_low = ~ack_bit; end
            ST_ACK_REL,
            ST_ACK_HIGH: d.sda_low = ~ack_bit;
            ST_STP_SDA,
            ST_STP_LOW:  begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_STP_REL,
            ST_STP_HIGH: d.sda_low = 1'b1;
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cas_sync.sv
module i2cas_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/i2cas_baud.sv
module i2cas_baud #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [RW-1:0] reload,
    output logic          zero
);
    localparam logic [RW-1:0] MIN_RELOAD = RW'(1);

    logic [RW-1:0] cnt;
    logic [RW-1:0] eff;

    assign eff  = (reload == '0) ? MIN_RELOAD : reload;
    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= eff;
        else if (cnt != '0) cnt <= cnt - MIN_RELOAD;
    end
endmodule

// File: rtl/i2cas_fsm.sv
module i2cas_fsm
    import i2cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_en,
    input  logic       stop_en,
    input  logic       ack_bit,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       zero,
    output logic       load,
    output logic       ack_done,
    output logic       stop_done,
    output logic       stop_seen,
    output bus_drive_t drv
);
    seq_state_e state, nxt;
    logic       hold_scl;

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        ack_done  = 1'b0;
        stop_done = 1'b0;
        stop_seen = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ack_en) begin
                    nxt  = ST_ACK_LOW;
                    load = 1'b1;
                end else if (stop_en && !scl_s) begin
                    nxt = ST_STP_SDA;
                end
            end
            ST_ACK_LOW:  if (zero) nxt = ST_ACK_REL;
            ST_ACK_REL:  if (scl_s) begin nxt = ST_ACK_HIGH; load = 1'b1; end
            ST_ACK_HIGH: if (zero) begin nxt = ST_IDLE; ack_done = 1'b1; end
            ST_STP_SDA:  if (!sda_s) begin nxt = ST_STP_LOW; load = 1'b1; end
            ST_STP_LOW:  if (zero) nxt = ST_STP_REL;
            ST_STP_REL:  if (scl_s) begin nxt = ST_STP_HIGH; load = 1'b1; end
            ST_STP_HIGH: if (zero) nxt = ST_STP_FREE;
            ST_STP_FREE: if (sda_s && scl_s) begin
                nxt       = ST_STP_TAIL;
                load      = 1'b1;
                stop_seen = 1'b1;
            end
            ST_STP_TAIL: if (zero) begin nxt = ST_IDLE; stop_done = 1'b1; end
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hold_scl <= 1'b0;
        end else begin
            state <= nxt;
            if (ack_done)       hold_scl <= 1'b1;
            else if (stop_done) hold_scl <= 1'b0;
        end
    end

    assign drv = phase_drive(state, hold_scl, ack_bit);
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2cas_pkg::*;
#(
    parameter int RW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] reload,
    input  logic          ack_go,
    input  logic          ack_val,
    input  logic          stop_go,
    input  logic          buf_wr,
    input  logic [DW-1:0] buf_wdata,
    input  logic          irq_clr,
    input  logic          wcol_clr,
    input  logic          start_seen,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          ack_busy,
    output logic          stop_busy,
    output logic          irq,
    output logic          stop_det,
    output logic          wcol,
    output logic [DW-1:0] buf_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_s;
    logic              zero, load, ack_done, stop_done, stop_seen;
    logic              ack_bit, busy;
    bus_drive_t        drv;

    i2cas_sync #(.W(NLINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    i2cas_baud #(.RW(RW)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .reload (reload),
        .zero   (zero)
    );

    i2cas_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ack_en    (ack_busy),
        .stop_en   (stop_busy),
        .ack_bit   (ack_bit),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .zero      (zero),
        .load      (load),
        .ack_done  (ack_done),
        .stop_done (stop_done),
        .stop_seen (stop_seen),
        .drv       (drv)
    );

    assign busy          = ack_busy | stop_busy;
    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_busy  <= 1'b0;
            stop_busy <= 1'b0;
            ack_bit   <= 1'b0;
            irq       <= 1'b0;
            stop_det  <= 1'b0;
            wcol      <= 1'b0;
            buf_data  <= '0;
        end else begin
            if (ack_done)                ack_busy <= 1'b0;
            else if (ack_go && !ack_busy) begin
                ack_busy <= 1'b1;
                ack_bit  <= ack_val;
            end

            if (stop_done)    stop_busy <= 1'b0;
            else if (stop_go) stop_busy <= 1'b1;

            if (ack_done || stop_done) irq <= 1'b1;
            else if (irq_clr)          irq <= 1'b0;

            if (stop_seen)       stop_det <= 1'b1;
            else if (start_seen) stop_det <= 1'b0;

            if (buf_wr && busy)  wcol <= 1'b1;
            else if (wcol_clr)   wcol <= 1'b0;

            if (buf_wr && !busy) buf_data <= buf_wdata;
        end
    end
endmodule

// File: rtl/i2cas_checker.sv
module i2cas_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ack_busy,
    input logic          stop_busy,
    input logic          irq,
    input logic          stop_det,
    input logic          wcol,
    input logic          buf_wr,
    input logic [DW-1:0] buf_data,
    input logic          scl_drive_low,
    input logic          sda_drive_low
);
    a_r3_ack_end_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_busy) |-> irq);

    a_r7_stop_end_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_busy) |-> irq);

    a_r6_det_in_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_det) |-> stop_busy);

    a_r8_buf_frozen: assert property (@(posedge clk) disable iff (rst)
        (ack_busy || stop_busy) |=> $stable(buf_data));

    a_r8_wcol_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wcol) |-> $past(buf_wr && (ack_busy || stop_busy)));

    a_r3_sda_free_idle: assert property (@(posedge clk) disable iff (rst)
        !(ack_busy || stop_busy) |-> !sda_drive_low);

    a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (ack_busy && !scl_drive_low && $past(ack_busy && !scl_drive_low))
            |-> $stable(sda_drive_low));
endmodule

bind i2c_ackstop_seq i2cas_checker #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ack_busy      (ack_busy),
    .stop_busy     (stop_busy),
    .irq           (irq),
    .stop_det      (stop_det),
    .wcol          (wcol),
    .buf_wr        (buf_wr),
    .buf_data      (buf_data),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_ackstop_seq_test.sv
module i2c_ackstop_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 8;
    localparam int DW = 8;
    localparam int NREL = 3;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] reload = RW'(NREL);
    logic          ack_go = 0, ack_val = 0, stop_go = 0, buf_wr = 0;
    logic [DW-1:0] buf_wdata = '0;
    logic          irq_clr = 0, wcol_clr = 0, start_seen = 0;
    logic          scl_stretch = 0, sda_hold = 0;
    logic          scl_in, sda_in;
    logic          scl_drive_low, sda_drive_low, ack_busy, stop_busy;
    logic          irq, stop_det, wcol;
    logic [DW-1:0] buf_data;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    assign scl_in = !(scl_drive_low || scl_stretch);
    assign sda_in = !(sda_drive_low || sda_hold);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ackstop_seq #(.RW(RW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .reload(reload), .ack_go(ack_go), .ack_val(ack_val),
        .stop_go(stop_go), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .irq_clr(irq_clr), .wcol_clr(wcol_clr), .start_seen(start_seen),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .ack_busy(ack_busy), .stop_busy(stop_busy), .irq(irq),
        .stop_det(stop_det), .wcol(wcol), .buf_data(buf_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_ack(input bit v);
        @(negedge clk); ack_go = 1; ack_val = v;
        @(negedge clk); ack_go = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_go = 1;
        @(negedge clk); stop_go = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); irq_clr = 1; wcol_clr = 1; start_seen = 1;
        @(negedge clk); irq_clr = 0; wcol_clr = 0; start_seen = 0;
    endtask

    task automatic wait_idle();
        while (ack_busy || stop_busy) @(negedge clk);
    endtask

    // Low run of scl_drive_low, then high run of the SCL line, from a released bus.
    task automatic measure_ack(input bit v, output int lo, output int hi, output bit sda_ok);
        pulse_ack(v);
        while (!scl_drive_low) @(negedge clk);
        lo = 0; sda_ok = 1;
        while (scl_drive_low) begin
            if (sda_drive_low != !v) sda_ok = 0;
            lo++; @(negedge clk);
        end
        hi = 0;
        while (scl_in) begin
            if (sda_drive_low != !v) sda_ok = 0;
            hi++; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(!scl_drive_low && !sda_drive_low, "R12", "drive enables", {scl_drive_low, sda_drive_low}, 0);
        chk(!ack_busy && !stop_busy && !irq && !stop_det && !wcol, "R12", "flags",
            {ack_busy, stop_busy, irq, stop_det, wcol}, 0);
        chk(buf_data == 0, "R12", "buffer", buf_data, 0);
    endtask

    task automatic t_ack_basic();
        int lo, hi; bit ok;
        measure_ack(1'b0, lo, hi, ok);
        chk(lo == NREL + 1, "R1", "ack low phase clocks", lo, NREL + 1);
        chk(ok, "R1", "ACK drives SDA low through sequence", ok, 1);
        chk(hi == NREL + 4, "R2", "ack SCL high clocks", hi, NREL + 4);
        chk(!ack_busy && irq, "R3", "busy clear / irq set", {ack_busy, irq}, 1);
        chk(scl_drive_low && !sda_drive_low, "R3", "SCL held, SDA free",
            {scl_drive_low, sda_drive_low}, 2);
    endtask

    task automatic t_wcol();
        clear_flags();
        @(negedge clk); buf_wr = 1; buf_wdata = 8'h5A;
        @(negedge clk); buf_wr = 0;
        chk(buf_data == 8'h5A, "R8", "idle write stored", buf_data, 8'h5A);
        chk(!wcol, "R8", "idle write no collision", wcol, 0);
        pulse_ack(1'b1);
        @(negedge clk); buf_wr = 1; buf_wdata = 8'hC3;
        @(negedge clk); buf_wr = 0;
        chk(wcol, "R8", "busy write collision", wcol, 1);
        chk(buf_data == 8'h5A, "R8", "busy write rejected", buf_data, 8'h5A);
        wait_idle();
        chk(buf_data == 8'h5A, "R8", "buffer after sequence", buf_data, 8'h5A);
        @(negedge clk); wcol_clr = 1;
        @(negedge clk); wcol_clr = 0;
        chk(!wcol, "R9", "wcol cleared", wcol, 0);
        chk(irq, "R9", "irq before clear", irq, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk(!irq, "R9", "irq cleared", irq, 0);
    endtask

    task automatic t_stretch();
        int hi;
        scl_stretch = 1;
        pulse_ack(1'b0);
        while (!(ack_busy && !scl_drive_low)) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(ack_busy && !scl_in, "R2", "waits while SCL stretched", {ack_busy, scl_in}, 2);
        @(posedge clk); #1 scl_stretch = 0;
        @(negedge clk);
        hi = 0;
        while (scl_in) begin hi++; @(negedge clk); end
        chk(hi == NREL + 4, "R2", "high clocks after stretch", hi, NREL + 4);
        wait_idle();
    endtask

    task automatic t_stop();
        int n;
        clear_flags();
        pulse_stop();
        while (sda_in) @(negedge clk);
        n = 0;
        while (!scl_in) begin n++; @(negedge clk); end
        chk(n == NREL + 4, "R5", "SDA-low to SCL release", n, NREL + 4);
        n = 0;
        while (scl_in && !sda_in) begin n++; @(negedge clk); end
        chk(n == NREL + 4, "R5", "SCL-high to SDA release", n, NREL + 4);
        while (!stop_det) @(negedge clk);
        n = 0;
        while (!irq) begin n++; @(negedge clk); end
        chk(n == NREL + 1, "R7", "stop_det to irq clocks", n, NREL + 1);
        chk(!stop_busy && !scl_drive_low && !sda_drive_low, "R7", "stop end state",
            {stop_busy, scl_drive_low, sda_drive_low}, 0);
        @(negedge clk); start_seen = 1;
        @(negedge clk); start_seen = 0;
        chk(!stop_det, "R9", "start clears stop_det", stop_det, 0);
    endtask

    task automatic t_pending();
        clear_flags();
        pulse_stop();
        repeat (12) @(negedge clk);
        chk(stop_busy && !sda_drive_low && !scl_drive_low, "R4", "stop held while SCL high",
            {stop_busy, sda_drive_low, scl_drive_low}, 4);
        pulse_ack(1'b0);
        while (ack_busy) @(negedge clk);
        while (stop_busy && !sda_drive_low) @(negedge clk);
        chk(sda_drive_low && scl_drive_low, "R4", "stop drives SDA low with SCL low",
            {sda_drive_low, scl_drive_low}, 3);
        wait_idle();
        chk(stop_det && irq, "R4", "pending stop completes", {stop_det, irq}, 3);
    endtask

    task automatic t_both();
        clear_flags();
        @(negedge clk); ack_go = 1; ack_val = 1; stop_go = 1;
        @(negedge clk); ack_go = 0; stop_go = 0;
        while (!scl_drive_low) @(negedge clk);
        chk(ack_busy && !sda_drive_low, "R10", "ack phase first (NACK)",
            {ack_busy, sda_drive_low}, 2);
        wait_idle();
        chk(!ack_busy && stop_det, "R10", "stop after ack", {ack_busy, stop_det}, 1);
    endtask

    task automatic t_sda_held();
        clear_flags();
        pulse_ack(1'b0);
        wait_idle();
        sda_hold = 1;
        pulse_stop();
        while (sda_drive_low || !scl_in) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(!stop_det && stop_busy, "R6", "no detect while SDA held", {stop_det, stop_busy}, 1);
        sda_hold = 0;
        wait_idle();
        chk(stop_det, "R6", "detect after SDA freed", stop_det, 1);
    endtask

    task automatic t_reload0();
        int lo, hi; bit ok;
        clear_flags();
        reload = '0;
        measure_ack(1'b0, lo, hi, ok);
        chk(lo == 2, "R11", "zero reload low phase", lo, 2);
        chk(hi == 5, "R11", "zero reload high clocks", hi, 5);
        wait_idle();
        reload = RW'(NREL);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ack_basic();
        t_wcol();
        t_stretch();
        t_stop();
        t_pending();
        t_both();
        t_sda_held();
        t_reload0();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule